// File: doc/BRIEF.md
# Single-Cycle Processor Core with Sticky Halt

This block is a small 32-bit processor that completes one instruction on every clock edge. A single word-organised store holds both code and data. The core fetches from it combinationally. It decodes the word into control strobes, reads two operands from a 32-entry register file and computes with an eight-function ALU. It then commits at most one register write or one memory write, together with the next program counter, all at the same edge.

Any instruction the core cannot legally complete sets a sticky halt flag and does not commit. This covers an unknown encoding, a misaligned word access, a fetch, data access or control transfer outside the legal address space, and a misaligned control target. From then on the PC, the registers and the memory stay frozen until reset.

A program is written into the store through a load port, which is honoured only while reset is held. Final state is read through two combinational peek ports, one for a register and one for a memory word. The legal byte address space is `2**ADDR_W` (default 64 KB). The physical store holds `2**STORE_AW` words and is indexed by byte-address bits `[STORE_AW+1:2]`, so addresses that differ only above that field share a word. Words are big-endian: the lowest byte address of a word holds bits 31:24.

Top module: `core_top`

## Requirements
- R1: While `rst` is high and on its release, `pc` is `RESET_PC` (default 0x4000), `halt` is 0 and every register reads 0.
- R2: Opcode 0x00 with funct 0x20 add, 0x22 sub, 0x24 and, 0x25 or, 0x2A signed set-less-than or 0x2B unsigned set-less-than writes rs op rt to rd. The fields are rs bits 25:21, rt bits 20:16, rd bits 15:11 and funct bits 5:0.
- R3: The following opcodes write their result to rt, using the sign-extended immediate in bits 15:0: 0x08 add-immediate, 0x0A signed compare-immediate and 0x0B unsigned compare-immediate. Opcode 0x0F writes the immediate shifted left by 16 to rt.
- R4: Opcode 0x23 loads the word at rs+sext(imm) into rt. Opcode 0x2B stores rt to that address. The load value is available in the same cycle.
- R5: Opcode 0x04 branches to PC+4+(sext(imm)<<2) when rs equals rt. Opcode 0x02 jumps to {PC+4[31:28], bits 25:0, 2'b00}. All other instructions go to PC+4.
- R6: Writes to register 0 are accepted, but register 0 always reads 0.
- R7: Any other opcode or R-type funct, including the all-zero word, sets `halt`.
- R8: A load or store whose address is not a multiple of 4 sets `halt`.
- R9: A fetch, load, store, taken branch or jump whose address has any bit at or above `ADDR_W` set sets `halt`.
- R10: The instruction that sets `halt` writes no register and no memory, and `pc` keeps its address.
- R11: Once set, `halt` stays 1 and `pc`, the registers and the memory stay unchanged until reset.
- R12: `loadEn` writes `loadData` at `loadAddr` only while `rst` is high. The store is indexed by address bits `[STORE_AW+1:2]`, so with the defaults 0x0000 and 0x4000 are the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| loadEn | input | 1 | Program/data load strobe, honoured during reset |
| loadAddr | input | ADDR_W | Byte address of the loaded word |
| loadData | input | 32 | Word to load |
| peekReg | input | 5 | Register index to observe |
| peekRegData | output | 32 | Value of the observed register |
| peekAddr | input | ADDR_W | Byte address of the memory word to observe |
| peekMemData | output | 32 | Value of the observed memory word |
| pc | output | 32 | Current program counter |
| halt | output | 1 | Sticky halt flag |

## Verification
A wrong internal state does not stay hidden for long. A bad ALU function, operand select or write-back destination shows up in the peeked registers once the program halts. A bad branch or jump target shows up as a skipped or extra register write, or as a different final `pc`. A missed halt condition shows up one edge after the offending instruction, either as `pc` moving past it or as a register or memory write that the peek ports expose. Leaks in the halt freeze show up as `pc` or memory drifting over the idle cycles the bench waits after halt.

// File: rtl/core_pkg.sv
package core_pkg;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_SLT  = 3'd2,
    ALU_SLTU = 3'd3,
    ALU_AND  = 3'd4,
    ALU_OR   = 3'd5,
    ALU_LUI  = 3'd6,
    ALU_NOR  = 3'd7
  } aluOp_e;

  typedef struct packed {
    logic   regWrite;
    logic   destRd;
    logic   useImm;
    logic   memRead;
    logic   memWrite;
    logic   branch;
    logic   jump;
    aluOp_e aluOp;
    logic   illegal;
  } ctrl_t;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JUMP  = 6'h02;
  localparam logic [5:0] OP_BEQ   = 6'h04;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_SLTI  = 6'h0A;
  localparam logic [5:0] OP_SLTIU = 6'h0B;
  localparam logic [5:0] OP_LUI   = 6'h0F;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD  = 6'h20;
  localparam logic [5:0] FN_SUB  = 6'h22;
  localparam logic [5:0] FN_AND  = 6'h24;
  localparam logic [5:0] FN_OR   = 6'h25;
  localparam logic [5:0] FN_SLT  = 6'h2A;
  localparam logic [5:0] FN_SLTU = 6'h2B;

endpackage

// File: rtl/core_alu.sv
module core_alu
  import core_pkg::*;
(
  input  logic [31:0] a,
  input  logic [31:0] b,
  input  aluOp_e      op,
  output logic [31:0] y,
  output logic        zero
);
  always_comb begin
    unique case (op)
      ALU_ADD:  y = a + b;
      ALU_SUB:  y = a - b;
      ALU_SLT:  y = {31'd0, $signed(a) < $signed(b)};
      ALU_SLTU: y = {31'd0, a < b};
      ALU_AND:  y = a & b;
      ALU_OR:   y = a | b;
      ALU_LUI:  y = {b[15:0], 16'd0};
      default:  y = ~(a | b);
    endcase
  end
  assign zero = (y == 32'd0);
endmodule

// File: rtl/core_ctrl.sv
module core_ctrl
  import core_pkg::*;
(
  input  logic [5:0] opcode,
  input  logic [5:0] funct,
  output ctrl_t      ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.aluOp = ALU_ADD;
    unique case (opcode)
      OP_RTYPE: begin
        ctrl.regWrite = 1'b1;
        ctrl.destRd   = 1'b1;
        unique case (funct)
          FN_ADD:  ctrl.aluOp = ALU_ADD;
          FN_SUB:  ctrl.aluOp = ALU_SUB;
          FN_AND:  ctrl.aluOp = ALU_AND;
          FN_OR:   ctrl.aluOp = ALU_OR;
          FN_SLT:  ctrl.aluOp = ALU_SLT;
          FN_SLTU: ctrl.aluOp = ALU_SLTU;
          default: begin
            ctrl.regWrite = 1'b0;
            ctrl.illegal  = 1'b1;
          end
        endcase
      end
      OP_ADDI:  begin ctrl.regWrite = 1'b1; ctrl.useImm = 1'b1; end
      OP_SLTI:  begin ctrl.regWrite = 1'b1; ctrl.useImm = 1'b1; ctrl.aluOp = ALU_SLT;  end
      OP_SLTIU: begin ctrl.regWrite = 1'b1; ctrl.useImm = 1'b1; ctrl.aluOp = ALU_SLTU; end
      OP_LUI:   begin ctrl.regWrite = 1'b1; ctrl.useImm = 1'b1; ctrl.aluOp = ALU_LUI;  end
      OP_LOAD:  begin ctrl.regWrite = 1'b1; ctrl.useImm = 1'b1; ctrl.memRead = 1'b1; end
      OP_STORE: begin ctrl.useImm = 1'b1; ctrl.memWrite = 1'b1; end
      OP_BEQ:   begin ctrl.branch = 1'b1; ctrl.aluOp = ALU_SUB; end
      OP_JUMP:  ctrl.jump = 1'b1;
      default:  ctrl.illegal = 1'b1;
    endcase
  end
endmodule

// File: rtl/core_datapath.sv
module core_datapath
  import core_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          STORE_AW = 11,
  parameter logic [31:0] RESET_PC = 32'h0000_4000
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrl_t             ctrl,
  output logic [31:0]       instr,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [31:0]       loadData,
  input  logic [4:0]        peekReg,
  output logic [31:0]       peekRegData,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [31:0]       peekMemData,
  output logic [31:0]       pc,
  output logic              halt
);
  localparam int WORDS = 2 ** STORE_AW;
  localparam int IDX_HI = STORE_AW + 1;

  logic [31:0] pcQ;
  logic        haltQ;
  logic [31:0] regs [32];
  logic [31:0] store [WORDS];

  logic [4:0]  rsIdx, rtIdx, rdIdx, wbIdx;
  logic [31:0] rsVal, rtVal, immExt, aluB, aluY, loadVal, wbVal;
  logic [31:0] pcPlus4, brTarget, jTarget, nextPc;
  logic        aluZero, takeBr, fetchBad, ctlBad, dataBad, haltNow, commit;

  function automatic logic outOfRange(input logic [31:0] addr);
    return |(addr >> ADDR_W);
  endfunction

  assign instr  = store[pcQ[IDX_HI:2]];
  assign rsIdx  = instr[25:21];
  assign rtIdx  = instr[20:16];
  assign rdIdx  = instr[15:11];
  assign rsVal  = (rsIdx == 5'd0) ? 32'd0 : regs[rsIdx];
  assign rtVal  = (rtIdx == 5'd0) ? 32'd0 : regs[rtIdx];
  assign immExt = {{16{instr[15]}}, instr[15:0]};
  assign aluB   = ctrl.useImm ? immExt : rtVal;

  core_alu uAlu (.a(rsVal), .b(aluB), .op(ctrl.aluOp), .y(aluY), .zero(aluZero));

  assign pcPlus4  = pcQ + 32'd4;
  assign brTarget = pcPlus4 + {immExt[29:0], 2'b00};
  assign jTarget  = {pcPlus4[31:28], instr[25:0], 2'b00};
  assign takeBr   = ctrl.branch & aluZero;
  assign nextPc   = ctrl.jump ? jTarget : (takeBr ? brTarget : pcPlus4);

  assign fetchBad = outOfRange(pcQ) | (|pcQ[1:0]);
  assign ctlBad   = (ctrl.jump | takeBr) & (outOfRange(nextPc) | (|nextPc[1:0]));
  assign dataBad  = (ctrl.memRead | ctrl.memWrite) & (outOfRange(aluY) | (|aluY[1:0]));
  assign haltNow  = fetchBad | ctrl.illegal | ctlBad | dataBad;
  assign commit   = !rst && !haltQ && !haltNow;

  assign loadVal = store[aluY[IDX_HI:2]];
  assign wbVal   = ctrl.memRead ? loadVal : aluY;
  assign wbIdx   = ctrl.destRd ? rdIdx : rtIdx;

  always_ff @(posedge clk) begin
    if (rst) begin
      pcQ   <= RESET_PC;
      haltQ <= 1'b0;
    end else if (!haltQ) begin
      if (haltNow) haltQ <= 1'b1;
      else         pcQ   <= nextPc;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 32; i++) regs[i] <= 32'd0;
    end else if (commit && ctrl.regWrite && wbIdx != 5'd0) begin
      regs[wbIdx] <= wbVal;
    end
  end

  always_ff @(posedge clk) begin
    if (rst && loadEn)                  store[loadAddr[IDX_HI:2]] <= loadData;
    else if (commit && ctrl.memWrite)   store[aluY[IDX_HI:2]]     <= rtVal;
  end

  assign peekRegData = (peekReg == 5'd0) ? 32'd0 : regs[peekReg];
  assign peekMemData = store[peekAddr[IDX_HI:2]];
  assign pc   = pcQ;
  assign halt = haltQ;

  logic unusedBits;
  assign unusedBits = ^{instr[10:6], loadAddr, peekAddr, aluY, pcQ, nextPc};
endmodule

// File: rtl/core_top.sv
module core_top
  import core_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter int          STORE_AW = 11,
  parameter logic [31:0] RESET_PC = 32'h0000_4000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              loadEn,
  input  logic [ADDR_W-1:0] loadAddr,
  input  logic [31:0]       loadData,
  input  logic [4:0]        peekReg,
  output logic [31:0]       peekRegData,
  input  logic [ADDR_W-1:0] peekAddr,
  output logic [31:0]       peekMemData,
  output logic [31:0]       pc,
  output logic              halt
);
  ctrl_t       ctrl;
  logic [31:0] instr;

  core_ctrl uCtrl (.opcode(instr[31:26]), .funct(instr[5:0]), .ctrl(ctrl));

  core_datapath #(.ADDR_W(ADDR_W), .STORE_AW(STORE_AW), .RESET_PC(RESET_PC)) uDp (
    .clk(clk), .rst(rst), .ctrl(ctrl), .instr(instr),
    .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .peekReg(peekReg), .peekRegData(peekRegData),
    .peekAddr(peekAddr), .peekMemData(peekMemData),
    .pc(pc), .halt(halt)
  );
endmodule

// File: rtl/core_top_chk.sv
module core_top_chk #(
  parameter logic [31:0] RESET_PC = 32'h0000_4000
) (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic        halt
);
  assert_reset_pc_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (pc == RESET_PC && !halt));

  assert_halt_sticky_R11: assert property (@(posedge clk) disable iff (rst)
    halt |=> halt);

  assert_frozen_pc_R11: assert property (@(posedge clk) disable iff (rst)
    halt |=> $stable(pc));

  assert_no_advance_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(halt) |-> $stable(pc));

  assert_pc_aligned_R5: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);
endmodule

bind core_top core_top_chk #(.RESET_PC(RESET_PC)) uChk (
  .clk(clk), .rst(rst), .pc(pc), .halt(halt)
);

// File: tb/sim_core_top.sv
`timescale 1ns/1ps
module sim_core_top;
  localparam int ADDR_W = 16;
  localparam int STORE_AW = 11;
  localparam int NWORDS = 37;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic loadEn = 1'b0;
  logic [ADDR_W-1:0] loadAddr = '0;
  logic [31:0] loadData = '0;
  logic [4:0] peekReg = '0;
  logic [31:0] peekRegData, peekMemData, pc;
  logic [ADDR_W-1:0] peekAddr = '0;
  logic halt;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  core_top #(.ADDR_W(ADDR_W), .STORE_AW(STORE_AW)) u0 (
    .clk(clk), .rst(rst), .loadEn(loadEn), .loadAddr(loadAddr), .loadData(loadData),
    .peekReg(peekReg), .peekRegData(peekRegData), .peekAddr(peekAddr),
    .peekMemData(peekMemData), .pc(pc), .halt(halt)
  );

  localparam logic [31:0] PROG [NWORDS] = '{
    // program 0: arithmetic, memory, branch, jump (23 words)
    32'h20010005, 32'h2002FFFD, 32'h00221820, 32'h00222022, 32'h00222824,
    32'h00223025, 32'h0041382A, 32'h0041402B, 32'h3C091234, 32'h284AFFFE,
    32'h2C2BFFFF, 32'h200C0100, 32'hAD830004, 32'h8D8D0004, 32'h00210020,
    32'h10210001, 32'h200E0063, 32'h08001014, 32'h200E004D, 32'h00000000,
    32'h10220005, 32'h200F0001, 32'h00000000,
    // program 1: misaligned load
    32'h20010101, 32'h8C220000,
    // program 2: out-of-range store
    32'h3C010001, 32'h20030007, 32'hAC230000,
    // program 3: out-of-range jump
    32'h08004000,
    // program 4: illegal funct
    32'h20010005, 32'h00221821,
    // program 5: backward branch loop
    32'h20010003, 32'h2021FFFF, 32'h20420001, 32'h10200001, 32'h1000FFFC,
    32'h00000000
  };
  localparam int PSTART [6] = '{0, 23, 25, 28, 29, 31};
  localparam int PLEN   [6] = '{23, 2, 3, 1, 2, 6};

  // expected registers after program 0: {index, value}
  localparam logic [36:0] EXP0 [16] = '{
    {5'd1, 32'h00000005}, {5'd2, 32'hFFFFFFFD}, {5'd3, 32'h00000002},
    {5'd4, 32'h00000008}, {5'd5, 32'h00000005}, {5'd6, 32'hFFFFFFFD},
    {5'd7, 32'h00000001}, {5'd8, 32'h00000000}, {5'd9, 32'h12340000},
    {5'd10, 32'h00000001}, {5'd11, 32'h00000001}, {5'd12, 32'h00000100},
    {5'd13, 32'h00000002}, {5'd14, 32'h00000000}, {5'd15, 32'h00000001},
    {5'd0, 32'h00000000}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic peekR(input logic [4:0] r, output logic [31:0] v);
    peekReg = r;
    #1 v = peekRegData;
  endtask

  task automatic peekM(input logic [15:0] a, output logic [31:0] v);
    peekAddr = a;
    #1 v = peekMemData;
  endtask

  task automatic runProg(input int p, input string req);
    logic [31:0] v;
    int waited;
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < 2 ** STORE_AW; i++) begin
      loadEn = 1'b1; loadAddr = 16'(i * 4); loadData = 32'd0;
      @(negedge clk);
    end
    for (int i = 0; i < PLEN[p]; i++) begin
      loadEn = 1'b1; loadAddr = 16'(32'h4000 + i * 4); loadData = PROG[PSTART[p] + i];
      @(negedge clk);
    end
    loadEn = 1'b0;
    // R1: state held in reset
    #1;
    chk("R1 pc in reset", pc, 32'h4000);
    chk("R1 halt in reset", {31'd0, halt}, 32'd0);
    peekR(5'd5, v);
    chk("R1 register cleared", v, 32'd0);
    @(negedge clk);
    rst = 1'b0;
    waited = 0;
    while (!halt && waited < 2000) begin
      @(negedge clk);
      waited++;
    end
    chk({req, " reached halt"}, {31'd0, halt}, 32'd1);
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog: actual %0d expected below 150000", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] v, pcHeld;

    // program 0: table of expected registers walked by one loop (R2, R3, R4, R5, R6)
    runProg(0, "R7 all-zero word");
    for (int i = 0; i < 16; i++) begin
      peekR(EXP0[i][36:32], v);
      chk($sformatf("R2/R3/R4/R5/R6 reg %0d", EXP0[i][36:32]), v, EXP0[i][31:0]);
    end
    chk("R7 halt pc on zero word", pc, 32'h4058);
    peekM(16'h0104, v);
    chk("R4 stored word", v, 32'h00000002);
    pcHeld = pc;
    repeat (5) @(negedge clk);
    #1 chk("R11 pc frozen", pc, pcHeld);
    chk("R11 halt sticky", {31'd0, halt}, 32'd1);
    // R12: load ignored outside reset
    loadEn = 1'b1; loadAddr = 16'h0104; loadData = 32'hDEADBEEF;
    @(negedge clk);
    loadEn = 1'b0;
    peekM(16'h0104, v);
    chk("R12 load ignored when not in reset", v, 32'h00000002);

    // program 1: misaligned load (R8, R10)
    runProg(1, "R8 misaligned load");
    chk("R8 halt pc", pc, 32'h4004);
    peekR(5'd1, v);
    chk("R8 base register", v, 32'h00000101);
    peekR(5'd2, v);
    chk("R10 load target untouched", v, 32'd0);

    // program 2: out-of-range store aliasing onto code (R9, R10, R12)
    runProg(2, "R9 out-of-range store");
    chk("R9 halt pc", pc, 32'h4008);
    peekR(5'd1, v);
    chk("R3 lui result", v, 32'h00010000);
    peekM(16'h4000, v);
    chk("R10 store suppressed", v, 32'h3C010001);
    peekM(16'h0000, v);
    chk("R12 aliased word", v, 32'h3C010001);

    // program 3: out-of-range jump (R9, R10)
    runProg(3, "R9 out-of-range jump");
    chk("R10 pc stays on jump", pc, 32'h4000);

    // program 4: illegal funct (R7, R10)
    runProg(4, "R7 illegal funct");
    chk("R7 halt pc", pc, 32'h4004);
    peekR(5'd3, v);
    chk("R10 rd not written", v, 32'd0);

    // program 5: backward branch loop (R5)
    runProg(5, "R5 loop");
    peekR(5'd2, v);
    chk("R5 loop iterations", v, 32'd3);
    peekR(5'd1, v);
    chk("R5 loop counter", v, 32'd0);
    chk("R5 exit pc", pc, 32'h4014);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule